// File: doc/BRIEF.md
# Open-Drain I/O Port Bank with Key-On Wakeup

This block is a bank of general-purpose pins whose outputs are open-drain. Each pin owns an output latch: a latch holding 0 pulls the pad low, and a latch holding 1 releases it, so the pin can be read as an input. Software reaches the bank through single-cycle register writes. These writes update the latches, the pull-up enables, the wakeup enables and the alternate-input enables. The bank returns synchronized pin values, a pad output-enable for each pin, and a pad pull-up control for each pin.

The pins fall into three groups. The first is a single-bit group whose pins are set or cleared one at a time by index. The second is a nibble group written as a whole. The third is a pair group, also written as a whole. Pull-up and key-on wakeup are switched on or off for each group. While the device is in its low-power hold, a wakeup request is raised whenever a released pin in a wakeup-enabled group reads low. Two pins of the nibble group also feed alternate inputs: an interrupt input and a counter clock input. These pins stay readable through the normal read path while their alternate input is enabled.

Top module: `od_gpio_port`

Pins are packed into the flat vectors as follows: the single-bit group in the low `BIT_W` bits, then the nibble group, then the pair group in the top bits.

## Requirements
- R1: After reset every latch is 1, so `pad_oe` is all 0. Pull-ups, wakeup enables and alternate enables are all off, `wake_req` is 0, and `rd_pins` and `alt_in` are all 1.
- R2: `pad_oe[i]` is 1 (pad driven low) exactly when the latch of pin i holds 0. A write takes effect on the clock edge that samples it.
- R3: `wr_op`=0 sets and `wr_op`=1 clears the single-bit-group latch whose index is `wr_data`. No other latch changes. An index at or above `BIT_W` changes nothing.
- R4: `wr_op`=2 loads the nibble-group latches from `wr_data[NIB_W-1:0]`. `wr_op`=3 loads the pair-group latches from `wr_data[PAIR_W-1:0]`. Other groups are untouched.
- R5: `wr_op`=4 loads the pull-up enables from `wr_data[2:0]` (bit 0 = single-bit group, bit 1 = nibble, bit 2 = pair). `pad_pu[i]` is 1 exactly when the group of pin i is enabled and its latch holds 1.
- R6: `rd_pins` shows `pad_in` delayed through `SYNC_STAGES` registers. With the default, a pad change is visible after the second clock edge and not after the first.
- R7: `wr_op`=5 loads the wakeup enables from `wr_data[2:0]`, with the same bit order as R5. `wake_req` is 1 exactly when `hold` is 1 and some pin has its group enabled, its latch at 1 and its synchronized value at 0.
- R8: With `hold` at 0, or with the low pin's group not wakeup-enabled, or with the low pin's latch at 0, `wake_req` stays 0.
- R9: `wr_op`=6 loads the alternate enables from `wr_data[1:0]`. When bit 0 is set, `alt_in[0]` (counter input) follows the synchronized nibble pin `NIB_W-2`. When bit 1 is set, `alt_in[1]` (interrupt input) follows the synchronized nibble pin `NIB_W-1`. A disabled alternate input idles at 1. `rd_pins` is unaffected by these enables.
- R10: A write with `wr_op`=7 changes no latch or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 3 | Write operation code (see R3 to R10) |
| wr_data | input | DATA_W | Write data or bit index |
| hold | input | 1 | Device is in low-power hold |
| pad_in | input | BIT_W+NIB_W+PAIR_W | Pad input levels |
| pad_oe | output | BIT_W+NIB_W+PAIR_W | 1 = pull pad low |
| pad_pu | output | BIT_W+NIB_W+PAIR_W | 1 = enable pad pull-up |
| rd_pins | output | BIT_W+NIB_W+PAIR_W | Synchronized pin values |
| alt_in | output | 2 | Alternate inputs: bit 0 counter clock, bit 1 interrupt |
| wake_req | output | 1 | Key-on wakeup request |

## Verification
The bench builds the block with its defaults: four single-bit pins, a four-pin nibble group, a two-pin pair group, four data bits and two synchronizer stages. With four data bits, the bench can reach indices 4 to 15, which lie beyond the single-bit group, so the ignored-index case is exercised. With two stages, the bench can observe the exact edge on which a pad change shows up. A bench-side pad model ties each pad low whenever its latch drives it. This lets the bench show that a pin cleared by software never raises a wakeup on its own.

// File: rtl/odgp_pkg.sv
package odgp_pkg;

  typedef enum logic [2:0] {
    OP_SETB = 3'd0,
    OP_CLRB = 3'd1,
    OP_NIB  = 3'd2,
    OP_PAIR = 3'd3,
    OP_PULL = 3'd4,
    OP_WAKE = 3'd5,
    OP_ALT  = 3'd6,
    OP_NONE = 3'd7
  } wr_op_e;

  localparam int NGRP     = 3;
  localparam int GRP_BIT  = 0;
  localparam int GRP_NIB  = 1;
  localparam int GRP_PAIR = 2;

  // Group index of a pin in the packed pin vector.
  function automatic int group_of(input int pin, input int bit_w, input int nib_w);
    if (pin < bit_w)              return GRP_BIT;
    else if (pin < bit_w + nib_w) return GRP_NIB;
    else                          return GRP_PAIR;
  endfunction

  // A released pin of an enabled group seen low during hold asks for wakeup.
  function automatic logic pin_wakes(input logic latch_v, input logic sync_v,
                                     input logic grp_en, input logic hold_v);
    return hold_v & grp_en & latch_v & ~sync_v;
  endfunction

  // Pull-up applies only to a released pin of an enabled group.
  function automatic logic pin_pulls(input logic latch_v, input logic grp_en);
    return latch_v & grp_en;
  endfunction

endpackage

// File: rtl/od_latch_bank.sv
module od_latch_bank
  import odgp_pkg::*;
#(
  parameter int BIT_W  = 4,
  parameter int NIB_W  = 4,
  parameter int PAIR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [2:0]                        wr_op,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [BIT_W+NIB_W+PAIR_W-1:0]     latch,
  output logic [NGRP-1:0]                   pu_en,
  output logic [NGRP-1:0]                   wk_en,
  output logic [1:0]                        alt_en,
  output logic                              bit_idx_ok
);
  localparam int N        = BIT_W + NIB_W + PAIR_W;
  localparam int NIB_LO   = BIT_W;
  localparam int PAIR_LO  = BIT_W + NIB_W;

  logic [BIT_W-1:0]  bit_q;
  logic [NIB_W-1:0]  nib_q;
  logic [PAIR_W-1:0] pair_q;
  wr_op_e            op;

  assign op         = wr_op_e'(wr_op);
  assign bit_idx_ok = (int'(wr_data) < BIT_W);

  // Single-bit group: one flop per pin, each decoding its own index.
  for (genvar i = 0; i < BIT_W; i++) begin : g_bit
    logic hit;
    assign hit = wr_en && (int'(wr_data) == i);
    always_ff @(posedge clk) begin
      if (rst)                         bit_q[i] <= 1'b1;
      else if (hit && op == OP_SETB)   bit_q[i] <= 1'b1;
      else if (hit && op == OP_CLRB)   bit_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_q  <= '1;
      pair_q <= '1;
      pu_en  <= '0;
      wk_en  <= '0;
      alt_en <= '0;
    end else if (wr_en) begin
      case (op)
        OP_NIB:  nib_q  <= wr_data[NIB_W-1:0];
        OP_PAIR: pair_q <= wr_data[PAIR_W-1:0];
        OP_PULL: pu_en  <= wr_data[NGRP-1:0];
        OP_WAKE: wk_en  <= wr_data[NGRP-1:0];
        OP_ALT:  alt_en <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  assign latch[BIT_W-1:0]        = bit_q;
  assign latch[PAIR_LO-1:NIB_LO] = nib_q;
  assign latch[N-1:PAIR_LO]      = pair_q;

endmodule

// File: rtl/od_in_sync.sv
module od_in_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         st[s] <= '1;
      else if (s == 0) st[s] <= din;
      else             st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = st[STAGES-1];

endmodule

// File: rtl/od_wake_detect.sv
module od_wake_detect
  import odgp_pkg::*;
#(
  parameter int BIT_W  = 4,
  parameter int NIB_W  = 4,
  parameter int PAIR_W = 2
) (
  input  logic [BIT_W+NIB_W+PAIR_W-1:0] latch,
  input  logic [BIT_W+NIB_W+PAIR_W-1:0] sync_v,
  input  logic [NGRP-1:0]               wk_en,
  input  logic [NGRP-1:0]               pu_en,
  input  logic                          hold,
  output logic [BIT_W+NIB_W+PAIR_W-1:0] pin_wake,
  output logic [BIT_W+NIB_W+PAIR_W-1:0] pin_pull,
  output logic                          wake_any
);
  localparam int N = BIT_W + NIB_W + PAIR_W;

  for (genvar i = 0; i < N; i++) begin : g_pin
    localparam int G = group_of(i, BIT_W, NIB_W);
    assign pin_wake[i] = pin_wakes(latch[i], sync_v[i], wk_en[G], hold);
    assign pin_pull[i] = pin_pulls(latch[i], pu_en[G]);
  end

  assign wake_any = |pin_wake;

endmodule

// File: rtl/od_gpio_port.sv
module od_gpio_port
  import odgp_pkg::*;
#(
  parameter int BIT_W       = 4,
  parameter int NIB_W       = 4,
  parameter int PAIR_W      = 2,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_op,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          hold,
  input  logic [BIT_W+NIB_W+PAIR_W-1:0] pad_in,
  output logic [BIT_W+NIB_W+PAIR_W-1:0] pad_oe,
  output logic [BIT_W+NIB_W+PAIR_W-1:0] pad_pu,
  output logic [BIT_W+NIB_W+PAIR_W-1:0] rd_pins,
  output logic [1:0]                    alt_in,
  output logic                          wake_req
);
  localparam int N       = BIT_W + NIB_W + PAIR_W;
  localparam int CNT_PIN = BIT_W + NIB_W - 2;
  localparam int IRQ_PIN = BIT_W + NIB_W - 1;

  logic [N-1:0]      latch;
  logic [N-1:0]      sync_v;
  logic [N-1:0]      pin_wake;
  logic [N-1:0]      pin_pull;
  logic [NGRP-1:0]   pu_en;
  logic [NGRP-1:0]   wk_en;
  logic [1:0]        alt_en;
  logic              bit_idx_ok;
  logic              wake_any;

  od_latch_bank #(
    .BIT_W(BIT_W), .NIB_W(NIB_W), .PAIR_W(PAIR_W), .DATA_W(DATA_W)
  ) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
    .latch(latch), .pu_en(pu_en), .wk_en(wk_en), .alt_en(alt_en),
    .bit_idx_ok(bit_idx_ok)
  );

  od_in_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(sync_v)
  );

  od_wake_detect #(
    .BIT_W(BIT_W), .NIB_W(NIB_W), .PAIR_W(PAIR_W)
  ) u_wake (
    .latch(latch), .sync_v(sync_v), .wk_en(wk_en), .pu_en(pu_en), .hold(hold),
    .pin_wake(pin_wake), .pin_pull(pin_pull), .wake_any(wake_any)
  );

  assign pad_oe    = ~latch;
  assign pad_pu    = pin_pull;
  assign rd_pins   = sync_v;
  assign alt_in[0] = alt_en[0] ? sync_v[CNT_PIN] : 1'b1;
  assign alt_in[1] = alt_en[1] ? sync_v[IRQ_PIN] : 1'b1;
  assign wake_req  = wake_any;

endmodule

// File: rtl/od_gpio_port_chk.sv
module od_gpio_port_chk #(
  parameter int BIT_W       = 4,
  parameter int NIB_W       = 4,
  parameter int PAIR_W      = 2,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [2:0]                    wr_op,
  input logic [DATA_W-1:0]             wr_data,
  input logic                          hold,
  input logic [BIT_W+NIB_W+PAIR_W-1:0] pad_in,
  input logic [BIT_W+NIB_W+PAIR_W-1:0] pad_oe,
  input logic [BIT_W+NIB_W+PAIR_W-1:0] pad_pu,
  input logic [BIT_W+NIB_W+PAIR_W-1:0] rd_pins,
  input logic [1:0]                    alt_in,
  input logic                          wake_req,
  input logic                          bit_idx_ok
);
  localparam int NIB_LO  = BIT_W;
  localparam int PAIR_LO = BIT_W + NIB_W;
  localparam int IRQ_PIN = BIT_W + NIB_W - 1;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  a_r1_released_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (pad_oe == '0 && pad_pu == '0 && !wake_req));

  a_r4_nibble_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == 3'd2) |=> pad_oe[PAIR_LO-1:NIB_LO] == ~$past(wr_data[NIB_W-1:0]));

  a_r3_bad_index_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == 3'd1 && !bit_idx_ok) |=> $stable(pad_oe));

  a_r10_unused_op_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == 3'd7) |=> ($stable(pad_oe) && $stable(pad_pu)));

  a_r5_no_pull_on_driven: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_oe) == '0);

  a_r8_wake_needs_hold: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> hold);

  a_r9_irq_readable: assert property (@(posedge clk) disable iff (rst)
    !alt_in[1] |-> !rd_pins[IRQ_PIN]);

  if (SYNC_STAGES == 2) begin : g_sync2
    a_r6_two_stage_delay: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2) |-> rd_pins == $past(pad_in, 2));
  end

endmodule

bind od_gpio_port od_gpio_port_chk #(
  .BIT_W(BIT_W), .NIB_W(NIB_W), .PAIR_W(PAIR_W), .DATA_W(DATA_W),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
  .hold(hold), .pad_in(pad_in), .pad_oe(pad_oe), .pad_pu(pad_pu),
  .rd_pins(rd_pins), .alt_in(alt_in), .wake_req(wake_req),
  .bit_idx_ok(bit_idx_ok)
);

// File: tb/tb_od_gpio_port.sv
module tb_od_gpio_port;
  localparam int BW = 4, NW = 4, PW = 2, DW = 4, N = BW + NW + PW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_op = '0;
  logic [DW-1:0] wr_data = '0;
  logic          hold = 1'b0;
  logic [N-1:0]  ext_low = '0;
  logic [N-1:0]  pad_in, pad_oe, pad_pu, rd_pins;
  logic [1:0]    alt_in;
  logic          wake_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // Pad model: low if the bank drives it or the outside pulls it down.
  assign pad_in = ~pad_oe & ~ext_low;

  od_gpio_port dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
    .hold(hold), .pad_in(pad_in), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .rd_pins(rd_pins), .alt_in(alt_in), .wake_req(wake_req)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] op, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pad_oe == '0, "R1 oe", pad_oe, 0);
    chk(pad_pu == '0, "R1 pu", pad_pu, 0);
    chk(rd_pins == '1, "R1 rd", rd_pins, 10'h3ff);
    chk(alt_in == 2'b11 && !wake_req, "R1 alt/wake", {alt_in, wake_req}, 3'b110);
  endtask

  task automatic t_bits();
    wr(3'd1, 4'd2);
    chk(pad_oe == 10'h004, "R3 clear idx2", pad_oe, 10'h004);
    chk(pad_oe[2] == 1'b1, "R2 oe follows latch 0", pad_oe[2], 1);
    wr(3'd1, 4'd0);
    chk(pad_oe == 10'h005, "R3 clear idx0", pad_oe, 10'h005);
    wr(3'd1, 4'd9);
    chk(pad_oe == 10'h005, "R3 bad index ignored", pad_oe, 10'h005);
    wr(3'd0, 4'd2);
    chk(pad_oe == 10'h001, "R3 set idx2", pad_oe, 10'h001);
    wr(3'd0, 4'd0);
    chk(pad_oe == 10'h000, "R2 all released", pad_oe, 0);
  endtask

  task automatic t_groups();
    wr(3'd2, 4'b1010);
    chk(pad_oe == 10'h050, "R4 nibble load", pad_oe, 10'h050);
    wr(3'd3, 4'b1101);
    chk(pad_oe == 10'h250, "R4 pair load", pad_oe, 10'h250);
    wr(3'd2, 4'hf);
    wr(3'd3, 4'h3);
    chk(pad_oe == 10'h000, "R4 restored", pad_oe, 0);
  endtask

  task automatic t_pull();
    wr(3'd2, 4'b0110);
    wr(3'd4, 4'b010);
    chk(pad_pu == 10'h060, "R5 nibble pull on released", pad_pu, 10'h060);
    wr(3'd4, 4'b101);
    chk(pad_pu == 10'h30f, "R5 bit+pair pull", pad_pu, 10'h30f);
    wr(3'd4, 4'b000);
    wr(3'd2, 4'hf);
    chk(pad_pu == '0, "R5 pull off", pad_pu, 0);
  endtask

  task automatic t_sync();
    settle();
    @(negedge clk);
    ext_low[8] = 1'b1;
    @(negedge clk);
    chk(rd_pins[8] == 1'b1, "R6 not after one edge", rd_pins[8], 1);
    @(negedge clk);
    chk(rd_pins[8] == 1'b0, "R6 seen after two edges", rd_pins[8], 0);
    ext_low[8] = 1'b0;
    settle();
    chk(rd_pins == '1, "R6 released", rd_pins, 10'h3ff);
  endtask

  task automatic t_wake();
    wr(3'd5, 4'b010);
    hold = 1'b1;
    ext_low[5] = 1'b1;
    settle();
    chk(wake_req == 1'b1, "R7 wake on nibble low", wake_req, 1);
    hold = 1'b0;
    #1;
    chk(wake_req == 1'b0, "R8 no wake without hold", wake_req, 0);
    hold = 1'b1;
    wr(3'd5, 4'b101);
    chk(wake_req == 1'b0, "R8 group disabled", wake_req, 0);
    ext_low[5] = 1'b0;
    ext_low[1] = 1'b1;
    settle();
    chk(wake_req == 1'b1, "R7 wake on bit group", wake_req, 1);
    ext_low[1] = 1'b0;
    wr(3'd1, 4'd3);
    settle();
    chk(rd_pins[3] == 1'b0 && wake_req == 1'b0, "R8 driven pin no wake",
        {rd_pins[3], wake_req}, 2'b00);
    wr(3'd0, 4'd3);
    wr(3'd5, 4'b000);
    hold = 1'b0;
  endtask

  task automatic t_alt();
    ext_low[7] = 1'b1;
    settle();
    chk(alt_in == 2'b11, "R9 disabled idles high", alt_in, 2'b11);
    wr(3'd6, 4'b10);
    chk(alt_in == 2'b01, "R9 irq follows pin", alt_in, 2'b01);
    chk(rd_pins[7] == 1'b0, "R9 pin still readable", rd_pins[7], 0);
    ext_low[7] = 1'b0;
    ext_low[6] = 1'b1;
    wr(3'd6, 4'b11);
    settle();
    chk(alt_in == 2'b10, "R9 counter follows pin", alt_in, 2'b10);
    ext_low[6] = 1'b0;
    wr(3'd6, 4'b00);
  endtask

  task automatic t_unused();
    wr(3'd2, 4'b0011);
    wr(3'd4, 4'b010);
    wr(3'd7, 4'h0);
    chk(pad_oe == 10'h0c0 && pad_pu == 10'h030, "R10 unused op",
        {pad_oe, pad_pu}, {10'h0c0, 10'h030});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bits();
    t_groups();
    t_pull();
    t_sync();
    t_wake();
    t_alt();
    t_unused();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule